// File: doc/BRIEF.md
# Infrared Run-Length Receive Sampler

This block measures a demodulated infrared input line by how long it stays at one level. The line is first brought into the clock domain through a synchronizer. It is then sampled once per programmable sample period, which is given in microseconds. Each stretch of constant level becomes one byte. The top bit of the byte tells a space from a pulse. The low seven bits hold the number of sample periods the stretch lasted.

A stretch that lasts 127 periods is cut at that point and continues as further bytes of the same polarity. An idle line therefore keeps producing full-length space bytes until the receiver is turned off and on again. The bytes go into a small circular buffer. The block exposes the buffer's write pointer and raises a sticky interrupt when new bytes arrive. A host drains the buffer through a read port, keeps its own read pointer, and clears the interrupt when it is done.

Top module: `irrl_sampler`

## Requirements
- R1: The sample period is `period_us` microseconds (`period_us` × `CLK_PER_US` clocks) when `period_us` is in 5..127. Any value below 5 selects the default of 50 microseconds.
- R2: Each stored byte has bit 7 = 1 for a space (synchronized input low) and bit 7 = 0 for a pulse (input high). Bits 6:0 hold the run length, counted in sample periods, and this count is never zero.
- R3: When a sample instant sees the opposite level to the current run, the completed run is written as one byte. The new run starts with a count of 1.
- R4: A run that reaches 127 periods is written at once as a byte with count 127, and its count restarts from 0. The rest of the run follows as further bytes of the same polarity. When the level changes while the count is 0, no byte is written.
- R5: Each byte is written at `wr_ptr`, and `wr_ptr` then advances by one. After `DEPTH`-1 it wraps to 0. `rd_data` returns the byte stored at `rd_addr`.
- R6: While `rx_en` is low, no bytes are written. Re-enabling starts over with a fresh sample phase, a count of 0 and space polarity. Any partial run is dropped, which ends a running stream of spaces. The buffer contents and `wr_ptr` are kept.
- R7: `irq` rises the cycle after a byte is written and stays high until `irq_clr`. `irq_clr` clears it only in a cycle in which no byte is written.
- R8: After reset, `wr_ptr` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated IR line, high = pulse |
| period_us | input | 7 | Sample period in microseconds |
| rx_en | input | 1 | Receive engine enable |
| rd_addr | input | AW | Host read address into the buffer |
| rd_data | output | 8 | Byte stored at `rd_addr` |
| wr_ptr | output | AW | Next buffer slot to be written |
| irq | output | 1 | Sticky new-sample interrupt |
| irq_clr | input | 1 | Clears `irq` |

## Verification
A wrong run counter or polarity register shows up in the first byte written after the fault. That byte carries the wrong length or the wrong top bit, so the error is visible when the host reads it, one sample period after the run ends at the latest. A pointer or wrap fault moves `wr_ptr` to an unexpected slot on the very next write. A faulty enable path either writes bytes while disabled, or carries a stale count into the first byte after re-enabling. The bench drives runs whose lengths are exact multiples of the sample period. Each run therefore holds a known number of sample instants whatever the phase, and every drained byte can be predicted exactly.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
   localparam int RUN_W   = 7;
   localparam int RUN_MAX = (1 << RUN_W) - 1;

   typedef struct packed {
      logic             is_space;
      logic [RUN_W-1:0] len;
   } irrl_sample_t;
endpackage

// File: rtl/irrl_sync.sv
module irrl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/irrl_tick.sv
module irrl_tick #(
   parameter int CLK_PER_US = 4,
   parameter int DEF_PERIOD = 50,
   parameter int MIN_PERIOD = 5,
   parameter int PER_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PER_W-1:0] period_us,
   output logic             tick
);
   logic             us_stb;
   logic [PER_W-1:0] eff;
   logic [PER_W-1:0] us_cnt;

   generate
      if (CLK_PER_US == 1) begin : g_direct
         assign us_stb = en;
      end else begin : g_pre
         localparam int PW = $clog2(CLK_PER_US);
         logic [PW-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        pre <= '0;
            else if (!en)                      pre <= '0;
            else if (pre == PW'(CLK_PER_US-1)) pre <= '0;
            else                               pre <= pre + 1'b1;
         end
         assign us_stb = en && (pre == PW'(CLK_PER_US-1));
      end
   endgenerate

   assign eff  = (period_us < PER_W'(MIN_PERIOD)) ? PER_W'(DEF_PERIOD) : period_us;
   assign tick = us_stb && (us_cnt >= eff - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      us_cnt <= '0;
      else if (!en)    us_cnt <= '0;
      else if (us_stb) us_cnt <= tick ? '0 : us_cnt + 1'b1;
   end
endmodule

// File: rtl/irrl_run.sv
module irrl_run
   import irrl_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         lvl,
   output logic         commit,
   output irrl_sample_t sample
);
   logic             cur_space, nxt_space;
   logic [RUN_W-1:0] cnt, nxt_cnt;

   always_comb begin
      commit          = 1'b0;
      sample.is_space = cur_space;
      sample.len      = cnt;
      nxt_space       = cur_space;
      nxt_cnt         = cnt;
      if (tick) begin
         if ((!lvl) == cur_space) begin
            if (cnt == RUN_W'(RUN_MAX-1)) begin
               commit     = 1'b1;
               sample.len = RUN_W'(RUN_MAX);
               nxt_cnt    = '0;
            end else begin
               nxt_cnt = cnt + 1'b1;
            end
         end else begin
            commit    = (cnt != '0);
            nxt_space = !lvl;
            nxt_cnt   = RUN_W'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_space <= 1'b1;
         cnt       <= '0;
      end else if (!en) begin
         cur_space <= 1'b1;
         cnt       <= '0;
      end else begin
         cur_space <= nxt_space;
         cnt       <= nxt_cnt;
      end
   end
endmodule

// File: rtl/irrl_ring.sv
module irrl_ring #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic [AW-1:0] wr_ptr,
   input  logic          irq_clr,
   output logic          irq
);
   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] ptr_nxt;

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign ptr_nxt = wr_ptr + 1'b1;
         assign rd_data = mem[rd_addr];
      end else begin : g_cmp
         assign ptr_nxt = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
         assign rd_data = (rd_addr < AW'(DEPTH)) ? mem[rd_addr] : 8'h00;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         irq    <= 1'b0;
      end else begin
         if (wr_en) wr_ptr <= ptr_nxt;
         if (wr_en)        irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/irrl_sampler.sv
module irrl_sampler
   import irrl_pkg::*;
#(
   parameter int CLK_PER_US  = 4,
   parameter int DEPTH       = 16,
   parameter int DEF_PERIOD  = 50,
   parameter int MIN_PERIOD  = 5,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(DEPTH),
   localparam int PER_W      = RUN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_in,
   input  logic [PER_W-1:0] period_us,
   input  logic             rx_en,
   input  logic [AW-1:0]    rd_addr,
   output logic [7:0]       rd_data,
   output logic [AW-1:0]    wr_ptr,
   output logic             irq,
   input  logic             irq_clr
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("irrl_sampler: DEPTH must be at least 2");
      end
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("irrl_sampler: CLK_PER_US must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irrl_sampler: SYNC_STAGES must be at least 2");
      end
      if (MIN_PERIOD < 2 || DEF_PERIOD < MIN_PERIOD || DEF_PERIOD > RUN_MAX) begin : g_bad_per
         $error("irrl_sampler: period limits out of range");
      end
   endgenerate

   logic         ir_s;
   logic         tick;
   logic         commit_vld;
   irrl_sample_t commit_smp;
   logic [7:0]   commit_byte;

   assign commit_byte = commit_smp;

   irrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ir_in), .q(ir_s)
   );

   irrl_tick #(
      .CLK_PER_US(CLK_PER_US), .DEF_PERIOD(DEF_PERIOD),
      .MIN_PERIOD(MIN_PERIOD), .PER_W(PER_W)
   ) u_tick (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .period_us(period_us), .tick(tick)
   );

   irrl_run u_run (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick), .lvl(ir_s),
      .commit(commit_vld), .sample(commit_smp)
   );

   irrl_ring #(.DEPTH(DEPTH), .AW(AW)) u_ring (
      .clk(clk), .rst_n(rst_n), .wr_en(commit_vld), .wr_data(commit_byte),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
      .irq_clr(irq_clr), .irq(irq)
   );
endmodule

// File: rtl/irrl_sampler_chk.sv
module irrl_sampler_chk #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_en,
   input logic          irq_clr,
   input logic          irq,
   input logic [AW-1:0] wr_ptr,
   input logic          commit_vld,
   input logic [7:0]    commit_byte
);
   // R2
   nonzero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vld |-> (commit_byte[6:0] != 7'd0));

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr != $past(wr_ptr)) |->
      (wr_ptr == (($past(wr_ptr) == AW'(DEPTH-1)) ? AW'(0) : AW'($past(wr_ptr) + 1'b1))));

   // R5
   write_moves_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vld |=> (wr_ptr != $past(wr_ptr)));

   // R6
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> $stable(wr_ptr));

   // R7
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_vld |=> irq);

   // R7
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !commit_vld) |=> !irq);

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
endmodule

bind irrl_sampler irrl_sampler_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .irq_clr(irq_clr), .irq(irq),
   .wr_ptr(wr_ptr), .commit_vld(commit_vld), .commit_byte(commit_byte)
);

// File: tb/irrl_sampler_bench.sv
module irrl_sampler_bench;
   localparam int DEPTH = 16;
   localparam int AW    = $clog2(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ir_in = 1'b0;
   logic [6:0]    period_us = 7'd5;
   logic          rx_en = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [AW-1:0] wr_ptr;
   logic          irq;
   logic          irq_clr = 1'b0;

   int total = 0;
   int bad = 0;
   bit done = 0;

   irrl_sampler #(.CLK_PER_US(1), .DEPTH(DEPTH)) u_irrl_sampler (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .period_us(period_us),
      .rx_en(rx_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_ptr(wr_ptr),
      .irq(irq), .irq_clr(irq_clr)
   );

   always #10 clk = ~clk;

   // model state from the requirements
   bit         m_space;
   int         m_cnt;
   logic [7:0] exp_q[$];
   int         cur_eff;
   int         rd_ptr = 0;

   task automatic check(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // R1: effective period
   task automatic set_period(int p);
      period_us = 7'(p);
      cur_eff = (p < 5) ? 50 : p;
   endtask

   // R3 / R4 rule applied at one sample instant
   task automatic model_tick(bit pulse);
      bit sp;
      sp = !pulse;
      if (sp == m_space) begin
         if (m_cnt == 126) begin
            exp_q.push_back({m_space, 7'd127});
            m_cnt = 0;
         end else m_cnt++;
      end else begin
         if (m_cnt != 0) exp_q.push_back({m_space, 7'(m_cnt)});
         m_space = sp;
         m_cnt = 1;
      end
   endtask

   task automatic enable_rx();
      rx_en = 1'b1;
      m_space = 1'b1;
      m_cnt = 0;
   endtask

   task automatic drive_run(bit pulse, int n);
      ir_in = pulse;
      for (int i = 0; i < n; i++) model_tick(pulse);
      repeat (n * cur_eff) @(negedge clk);
   endtask

   // R6: turn off, then read back everything that should be stored
   task automatic drain(string tag);
      int cnt, skip;
      rx_en = 1'b0;
      repeat (3) @(negedge clk);
      cnt = exp_q.size();
      check(wr_ptr == AW'((rd_ptr + cnt) % DEPTH), "R5 wr_ptr", wr_ptr, (rd_ptr + cnt) % DEPTH);
      skip = (cnt > DEPTH) ? cnt - DEPTH : 0;
      for (int i = skip; i < cnt; i++) begin
         rd_addr = AW'((rd_ptr + i) % DEPTH);
         #1;
         check(rd_data === exp_q[i], tag, rd_data, exp_q[i]);
      end
      rd_ptr = (rd_ptr + cnt) % DEPTH;
      if (cnt > 0) check(irq === 1'b1, "R7 irq set", irq, 1);
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      check(irq === 1'b0, "R7 irq cleared", irq, 0);
      exp_q.delete();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int snap;
      void'($urandom(32'd7719));
      set_period(5);
      repeat (4) @(negedge clk);
      // R8: reset state
      check(wr_ptr == '0, "R8 wr_ptr", wr_ptr, 0);
      check(irq === 1'b0, "R8 irq", irq, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: plain alternating runs
      enable_rx();
      drive_run(0, 7); drive_run(1, 3); drive_run(0, 12); drive_run(1, 1); drive_run(0, 2);
      drain("R3 run bytes");

      // R4: saturation, exact 127, level change at zero count
      enable_rx();
      drive_run(1, 300); drive_run(0, 5); drive_run(1, 127); drive_run(0, 127);
      drive_run(1, 2); drive_run(0, 1);
      drain("R4 saturated bytes");

      // R1: other period, then out-of-range value falls back to default
      set_period(9);
      enable_rx();
      drive_run(0, 4); drive_run(1, 6); drive_run(0, 1);
      drain("R1 period 9");
      set_period(3);
      enable_rx();
      drive_run(0, 2); drive_run(1, 3); drive_run(0, 1);
      drain("R1 default period");
      set_period(0);
      enable_rx();
      drive_run(1, 2); drive_run(0, 1);
      drain("R1 zero period");

      // R6: idle stream of spaces cut by disable, fresh start after re-enable
      set_period(5);
      enable_rx();
      drive_run(0, 200);
      drain("R6 before disable");
      snap = wr_ptr;
      for (int i = 0; i < 60; i++) begin
         ir_in = i[2];
         @(negedge clk);
      end
      check(wr_ptr == AW'(snap), "R6 no write while off", wr_ptr, snap);
      check(irq === 1'b0, "R6 no irq while off", irq, 0);
      ir_in = 1'b0;
      repeat (3) @(negedge clk);
      enable_rx();
      drive_run(0, 10); drive_run(1, 4); drive_run(0, 1);
      drain("R6 after re-enable");

      // R5: more bytes than slots, pointer wraps
      enable_rx();
      for (int i = 0; i < 20; i++) drive_run(i[0], 2 + (i % 3));
      drain("R5 wrapped bytes");

      // random runs
      for (int b = 0; b < 10; b++) begin
         set_period($urandom_range(5, 12));
         enable_rx();
         for (int r = 0; r < 4; r++) drive_run(1'($urandom_range(0, 1)), $urandom_range(1, 260));
         drive_run(1'($urandom_range(0, 1)), 1);
         drain("R2 random bytes");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule